// File: doc/BRIEF.md
# Edge-Interval Bit Check Validator

This block decides whether a demodulated serial stream looks like a real transmitter preamble or like noise, before a receiver commits to receiving mode. After a start strobe it times the gap between consecutive transitions of the data input. The unit of time is a timing-clock enable (`tick_i`). Each gap is compared against a programmable acceptance window. The block counts consecutive accepted gaps until a programmable target is reached.

When the target is reached, the block enters receiving mode and forwards the data input to its data output. A single rejected gap, whether too short or too long, ends the check at once and parks the block in sleep. Sleep and receiving mode are held until the next start strobe or a reset. The window limits and the target selector are captured on the start strobe, so they may change freely while a check runs.

Top module: `bitcheck_validator`

## Requirements
- R1: While reset is held, and after it is released, `mode_o` reads 0 (idle) and `data_o` is 0. The mode codes are: 0 idle, 1 checking, 2 sleep, 3 receiving.
- R2: A start strobe with `count_sel_i` = 0 puts `mode_o` at 3 in the cycle after the strobe, with no gap checked.
- R3: The number of accepted gaps needed is 6 × `count_sel_i`, so 0, 6, 12 or 18. `mode_o` reads 1 until the edge that completes this count, and reads 3 in the cycle after that edge. The selector and both limits are captured on the start strobe.
- R4: A gap is accepted exactly when its measured length m satisfies `lim_lo_i` ≤ m ≤ `lim_hi_i` − 1. Both boundaries are inclusive.
- R5: A gap shorter than `lim_lo_i` puts `mode_o` at 2 in the cycle after the edge that closes it.
- R6: Once the gap in progress reaches `lim_hi_i` ticks, `mode_o` goes to 2 in the next cycle, with or without an edge.
- R7: The first edge after a start strobe only begins timing and is never judged. It may arrive after any delay without ending the check.
- R8: While `mode_o` is 3, `data_o` equals `data_i` in the same cycle.
- R9: While `mode_o` is not 3, `data_o` is 0.
- R10: Sleep and receiving mode are left only on a start strobe or reset. A start strobe in any mode begins a fresh check, so `mode_o` reads 1 in the next cycle when the target is non-zero.
- R11: A lower limit below 10 is used exactly as programmed, with no clamping.
- R12: An edge is a cycle in which `data_i` differs from its value in the previous cycle. A gap's length is the number of cycles with `tick_i` high, counted from the cycle after the previous edge up to and including the closing edge's cycle. Cycles without `tick_i` do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; begins a new check |
| tick_i | input | 1 | Timing-clock enable; one gap unit per high cycle |
| data_i | input | 1 | Demodulated serial data |
| count_sel_i | input | 2 | Target selector (0, 3, 6 or 9 bits) |
| lim_lo_i | input | 6 | Lower window limit in ticks |
| lim_hi_i | input | 6 | Upper window field; largest accepted gap is this minus one |
| mode_o | output | 2 | Mode code: 0 idle, 1 checking, 2 sleep, 3 receiving |
| data_o | output | 1 | Data passed through in receiving mode, else 0 |

## Verification
The main function is driven with several preamble patterns:
- evenly spaced edges, which reach receiving mode at exactly 6, 12 and 18 accepted gaps;
- gaps set exactly on the lower limit and on the upper limit minus one, which tell an inclusive bound from an off-by-one;
- one gap shortened or stretched inside an otherwise clean run, which shows whether a single failure ends the check and whether the too-long abort comes without an edge;
- a long silence before the first edge, which shows that the first edge is not judged;
- a half-rate timing enable, which tells gap measurement in ticks apart from measurement in clock cycles.

// File: rtl/bcv_pkg.sv
package bcv_pkg;
   typedef enum logic [1:0] {
      BCV_IDLE  = 2'd0,
      BCV_CHECK = 2'd1,
      BCV_SLEEP = 2'd2,
      BCV_RECV  = 2'd3
   } bcv_mode_e;
endpackage

// File: rtl/bcv_edge_detect.sv
module bcv_edge_detect #(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic edge_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LEVEL;
      else        prev_q <= din;
   end

   assign edge_o = din ^ prev_q;
endmodule

// File: rtl/bcv_interval_timer.sv
module bcv_interval_timer #(
   parameter int LIM_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   output logic [LIM_W:0]   meas_o
);
   localparam logic [LIM_W-1:0] CNT_MAX = '1;

   logic [LIM_W-1:0] cnt_q;

   // length of the running gap including the present cycle's tick
   assign meas_o = {1'b0, cnt_q} + {{LIM_W{1'b0}}, tick};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (clear)                     cnt_q <= '0;
      else if (tick && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/bcv_ctrl.sv
module bcv_ctrl
   import bcv_pkg::*;
#(
   parameter int LIM_W         = 6,
   parameter int SEL_W         = 2,
   parameter int BITS_PER_STEP = 3,
   parameter int EDGES_PER_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [SEL_W-1:0] sel,
   input  logic [LIM_W-1:0] lim_lo,
   input  logic [LIM_W-1:0] lim_hi,
   input  logic             edge_i,
   input  logic [LIM_W:0]   meas_i,
   output bcv_mode_e        mode_o
);
   localparam int NSEL    = 1 << SEL_W;
   localparam int MAX_TGT = (NSEL - 1) * BITS_PER_STEP * EDGES_PER_BIT;
   localparam int PCW     = (MAX_TGT < 2) ? 1 : $clog2(MAX_TGT + 1);

   logic [PCW-1:0]   tgt_tab [NSEL];
   logic [PCW-1:0]   target_q, pass_q, pass_nxt;
   logic [LIM_W-1:0] lo_q, hi_q;
   logic             armed_q;
   bcv_mode_e        mode_q;
   logic             in_win, too_long, too_short, good;

   for (genvar g = 0; g < NSEL; g++) begin : g_tgt
      assign tgt_tab[g] = PCW'(g * BITS_PER_STEP * EDGES_PER_BIT);
   end

   assign in_win    = (meas_i >= {1'b0, lo_q}) && (meas_i < {1'b0, hi_q});
   assign too_long  = armed_q && (meas_i >= {1'b0, hi_q});
   assign too_short = armed_q && edge_i && (meas_i < {1'b0, lo_q});
   assign good      = armed_q && edge_i && in_win;
   assign pass_nxt  = pass_q + PCW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= BCV_IDLE;
         armed_q  <= 1'b0;
         pass_q   <= '0;
         target_q <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
      end else if (start) begin
         target_q <= tgt_tab[sel];
         lo_q     <= lim_lo;
         hi_q     <= lim_hi;
         pass_q   <= '0;
         armed_q  <= 1'b0;
         mode_q   <= (tgt_tab[sel] == '0) ? BCV_RECV : BCV_CHECK;
      end else if (mode_q == BCV_CHECK) begin
         if (!armed_q) begin
            if (edge_i) armed_q <= 1'b1;
         end else if (too_long || too_short) begin
            mode_q <= BCV_SLEEP;
         end else if (good) begin
            pass_q <= pass_nxt;
            if (pass_nxt == target_q) mode_q <= BCV_RECV;
         end
      end
   end

   assign mode_o = mode_q;

   // R2
   zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && sel == '0) |=> mode_q == BCV_RECV);
   // R3
   pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_CHECK) |-> pass_q < target_q);
   // R5
   short_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_CHECK && !start && armed_q && edge_i && meas_i < {1'b0, lo_q})
      |=> mode_q == BCV_SLEEP);
   // R6
   long_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_CHECK && !start && armed_q && meas_i >= {1'b0, hi_q})
      |=> mode_q == BCV_SLEEP);
   // R7
   first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_CHECK && !armed_q && !start) |=> mode_q == BCV_CHECK);
   // R10
   recv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_RECV && !start) |=> mode_q == BCV_RECV);
   // R10
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == BCV_SLEEP && !start) |=> mode_q == BCV_SLEEP);
endmodule

// File: rtl/bitcheck_validator.sv
module bitcheck_validator
   import bcv_pkg::*;
#(
   parameter int LIM_W         = 6,
   parameter int SEL_W         = 2,
   parameter int BITS_PER_STEP = 3,
   parameter int EDGES_PER_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             tick_i,
   input  logic             data_i,
   input  logic [SEL_W-1:0] count_sel_i,
   input  logic [LIM_W-1:0] lim_lo_i,
   input  logic [LIM_W-1:0] lim_hi_i,
   output logic [1:0]       mode_o,
   output logic             data_o
);
   if (LIM_W < 2 || LIM_W > 16) begin : g_bad_lim
      $error("bitcheck_validator: LIM_W out of range");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("bitcheck_validator: SEL_W out of range");
   end
   if (BITS_PER_STEP < 1 || EDGES_PER_BIT < 1) begin : g_bad_step
      $error("bitcheck_validator: step sizes must be positive");
   end

   logic          edge_w;
   logic [LIM_W:0] meas_w;
   bcv_mode_e     mode_w;

   bcv_edge_detect #(.IDLE_LEVEL(1'b0)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (data_i),
      .edge_o (edge_w)
   );

   bcv_interval_timer #(.LIM_W(LIM_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_i),
      .clear  (edge_w),
      .meas_o (meas_w)
   );

   bcv_ctrl #(
      .LIM_W         (LIM_W),
      .SEL_W         (SEL_W),
      .BITS_PER_STEP (BITS_PER_STEP),
      .EDGES_PER_BIT (EDGES_PER_BIT)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_i),
      .sel    (count_sel_i),
      .lim_lo (lim_lo_i),
      .lim_hi (lim_hi_i),
      .edge_i (edge_w),
      .meas_i (meas_w),
      .mode_o (mode_w)
   );

   assign mode_o = mode_w;
   assign data_o = (mode_w == BCV_RECV) ? data_i : 1'b0;

   // R9
   gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != 2'd3 && !start_i) |=> (mode_o == 2'd3) || !data_o);
endmodule

// File: tb/bitcheck_validator_test.sv
module bitcheck_validator_test;
   localparam int PERIOD = 10;
   localparam logic [1:0] M_IDLE = 2'd0, M_CHECK = 2'd1, M_SLEEP = 2'd2, M_RECV = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, tick_i = 1'b1, data_i = 1'b0;
   logic [1:0] count_sel_i = '0;
   logic [5:0] lim_lo_i = '0, lim_hi_i = '0;
   logic [1:0] mode_o;
   logic data_o;

   int checks = 0, errors = 0;
   int unsigned cyc = 0;
   bit half_tick = 1'b0;
   bit finished = 1'b0;

   typedef struct {
      int unsigned cyc;
      logic [1:0]  mode;
      logic        dat;
      string       tag;
   } exp_t;
   exp_t q[$];

   bitcheck_validator uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
      .data_i(data_i), .count_sel_i(count_sel_i), .lim_lo_i(lim_lo_i),
      .lim_hi_i(lim_hi_i), .mode_o(mode_o), .data_o(data_o)
   );

   always #(PERIOD/2) clk = ~clk;

   // monitor: samples a quarter period after each rising edge
   always begin
      @(posedge clk);
      #(PERIOD/4);
      cyc++;
      while (q.size() > 0 && q[0].cyc <= cyc) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (mode_o !== e.mode || data_o !== e.dat) begin
            errors++;
            $display("FAIL %s @%0d: mode=%0d data=%0b expected mode=%0d data=%0b",
                     e.tag, cyc, mode_o, data_o, e.mode, e.dat);
         end
      end
   end

   task automatic push(input int unsigned d, input logic [1:0] m, input logic dv, input string tag);
      exp_t e;
      e.cyc = cyc + d; e.mode = m; e.dat = dv; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic step();
      @(negedge clk);
      tick_i = half_tick ? ~tick_i : 1'b1;
   endtask

   task automatic edge_now(input logic [1:0] m, input string tag);
      data_i = ~data_i;
      push(1, m, (m == M_RECV) ? data_i : 1'b0, tag);
   endtask

   task automatic run_seq(input logic [1:0] sel, input logic [5:0] lo, input logic [5:0] hi,
                          input int gap, input int ds[], input string tag);
      int tgt;
      int passes;
      logic [1:0] fin;
      tgt = int'(sel) * 6;
      passes = 0;
      step();
      start_i = 1'b1; count_sel_i = sel; lim_lo_i = lo; lim_hi_i = hi;
      push(1, (tgt == 0) ? M_RECV : M_CHECK, 1'b0, tag);
      step();
      start_i = 1'b0;
      lim_lo_i = 6'd0; lim_hi_i = 6'd63; count_sel_i = 2'd0; // captured already (R3)
      fin = (tgt == 0) ? M_RECV : M_CHECK;
      if (tgt != 0) begin
         repeat (gap) step();
         edge_now(M_CHECK, {tag, " first edge R7"});
         foreach (ds[i]) begin
            int m;
            m = half_tick ? ds[i] / 2 : ds[i];
            if (m >= int'(hi) && !half_tick) begin
               push(int'(hi), M_CHECK, 1'b0, {tag, " before limit R6"});
               push(int'(hi) + 1, M_SLEEP, 1'b0, {tag, " long abort R6"});
               repeat (int'(hi) + 2) step();
               fin = M_SLEEP;
               break;
            end else if (m < int'(lo)) begin
               repeat (ds[i]) step();
               edge_now(M_SLEEP, {tag, " short abort R5"});
               fin = M_SLEEP;
               break;
            end else begin
               passes++;
               fin = (passes == tgt) ? M_RECV : M_CHECK;
               repeat (ds[i]) step();
               edge_now(fin, {tag, " gap accepted R4"});
               if (fin == M_RECV) break;
            end
         end
      end
      // afterwards the mode must hold while data keeps toggling (R8 R9 R10)
      repeat (3) begin
         repeat (4) step();
         edge_now(fin, {tag, (fin == M_RECV) ? " passthrough R8" : " hold R9 R10"});
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during and after reset
      step();
      push(1, M_IDLE, 1'b0, "reset R1");
      step(); step();
      rst_n = 1'b1;
      push(1, M_IDLE, 1'b0, "after reset R1");
      step(); step();

      // R2: zero target
      run_seq(2'd0, 6'd10, 6'd14, 3, '{12}, "zero target R2");
      // R3: six steady gaps
      run_seq(2'd1, 6'd10, 6'd14, 3, '{12,12,12,12,12,12}, "six gaps R3");
      // R4: gaps on both window edges
      run_seq(2'd1, 6'd10, 6'd14, 3, '{10,13,10,13,11,12}, "window bounds R4");
      // R5: one short gap, then stay asleep (R10)
      run_seq(2'd2, 6'd10, 6'd14, 3, '{12,12,9,12}, "short gap R5");
      // R6: long silence after good gaps
      run_seq(2'd2, 6'd10, 6'd14, 3, '{12,30}, "long gap R6");
      // R6: gap exactly at the upper field value
      run_seq(2'd1, 6'd10, 6'd14, 3, '{12,14}, "gap at upper R6");
      // R7: long wait before first edge
      run_seq(2'd1, 6'd10, 6'd14, 40, '{12,12,12,12,12,12}, "late first edge R7");
      // R3: twelve gaps
      run_seq(2'd2, 6'd10, 6'd14, 3, '{11,11,11,11,11,11,11,11,11,11,11,11}, "twelve gaps R3");
      // R3: eighteen gaps
      run_seq(2'd3, 6'd10, 6'd14, 3,
              '{11,11,11,11,11,11,11,11,11,11,11,11,11,11,11,11,11,11}, "eighteen gaps R3");
      // R11: low lower limit kept as programmed
      run_seq(2'd1, 6'd3, 6'd6, 3, '{3,5,3,4,3,3}, "low limit R11");
      // R12: half-rate tick, gaps of 12 cycles measure 6 ticks
      half_tick = 1'b1;
      run_seq(2'd1, 6'd5, 6'd8, 3, '{12,12,12,12,12,12}, "half tick R12");
      // R12: 8 cycles measure 4 ticks, below the limit of 5
      run_seq(2'd1, 6'd5, 6'd8, 3, '{12,8}, "half tick short R12");
      half_tick = 1'b0;

      repeat (5) step();
      if (q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d expected items left unchecked, expected 0", q.size());
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule